// File: doc/BRIEF.md
# Shared Event Flag and Interrupt Unit

This block keeps a small bank of shared event flags for a group of internal agents, such as a few small sequencers working side by side. Any agent can raise or drop any flag, and any agent can ask whether a chosen flag is at a chosen level in the current cycle. No flag belongs to any one agent, so the flags serve as a general synchronisation point between the agents.

A host reaches the unit through a simple register port. It can read the flags and clear them one bit at a time. It can also raise them through a separate set register, and agents that wait on a flag see that change. The lower flags are combined with receive-not-empty and transmit-not-full conditions from the data channels into a raw interrupt vector. That vector drives several processor interrupt lines. Each line has its own enable register, force register and masked-status register. A line's force register acts only on that line. It never touches the flags that the agents see.

Top module: `evflag_irq_unit`

## Requirements
- R1: After reset all flags are 0. A flag goes to 1 on the clock edge after any agent's set request for it. It goes to 0 on the edge after any agent's clear request for it. With no request a flag holds its value. The set request of agent a for flag f is bit a*8+f of `agent_set`, and clear requests use the same positions in `agent_clr`.
- R2: A host write to address 0 clears every flag whose bit in the write data is 1, and leaves every flag whose bit is 0 unchanged. A read of address 0 returns the flags in bits 7:0.
- R3: A host write to address 1 sets every flag whose bit in the write data is 1. The change shows in the flags and on the wait ports on the next cycle.
- R4: When a set request and a clear request for the same flag arrive in the same cycle, from agents or from the host in any combination, the flag becomes 1.
- R5: For each agent a, `wait_met[a]` is 1 in the same cycle exactly when flag `wait_idx[3a+2:3a]` equals `wait_pol[a]`.
- R6: A read of address 2 returns the 12-bit raw vector. Bits 3:0 are `rx_not_empty[3:0]`, bits 7:4 are `tx_not_full[3:0]` and bits 11:8 are flags 3:0. Flags 7:4 never reach this vector.
- R7: Line k has an enable register at address 3+3k and a force register at address 4+3k, both 12 bits, read/write and 0 after reset. Its status at address 5+3k is (raw OR force) AND enable. `irq_out[k]` is the OR of that status.
- R8: A write to a line's force register changes neither the flags nor the raw vector.
- R9: Writes to the raw address, to a status address or to an unmapped address change no state. A read of address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| agent_set | input | 32 | Flag set requests, 8 bits per agent |
| agent_clr | input | 32 | Flag clear requests, 8 bits per agent |
| wait_idx | input | 12 | Flag index queried by each agent, 3 bits per agent |
| wait_pol | input | 4 | Level each agent waits for |
| wait_met | output | 4 | Wait condition met, per agent |
| rx_not_empty | input | 4 | Receive channel holds data, per channel |
| tx_not_full | input | 4 | Transmit channel has room, per channel |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| irq_out | output | 2 | Processor interrupt lines |

## Verification
A vector table drives the interrupt path with several distinct patterns. In one, only receive bits are enabled. In another, transmit bits reach one line but not the other. In a third, only flags are routed. The table also has a case where only the upper flags are set and every enable bit is on, and a case where an interrupt comes from the force register alone. Together these cases show whether each raw field sits in its stated position, whether the two lines are independent, and whether the upper flags are kept out of the raw vector. Directed cases then check each agent's set and clear, the clear-versus-no-op host write, and set winning over a clear from the host or from another agent in the same cycle. Further directed cases show that a line force leaves the agent-visible flags and the raw vector unchanged, and that writes to read-only or unmapped addresses have no effect.

// File: rtl/evf_pkg.sv
package evf_pkg;

   // Register addresses of the host port
   localparam int unsigned REG_FLAGS     = 0;
   localparam int unsigned REG_FLAG_SET  = 1;
   localparam int unsigned REG_RAW       = 2;
   localparam int unsigned REG_LINE_BASE = 3;
   localparam int unsigned LINE_STRIDE   = 3;

   typedef enum int unsigned {
      SLOT_EN    = 0,
      SLOT_FORCE = 1,
      SLOT_STAT  = 2
   } line_slot_e;

   function automatic int unsigned line_reg(input int unsigned line, input line_slot_e slot);
      return REG_LINE_BASE + LINE_STRIDE * line + int'(slot);
   endfunction

endpackage

// File: rtl/evf_flag_bank.sv
module evf_flag_bank #(
   parameter int unsigned NUM_FLAGS  = 8,
   parameter int unsigned NUM_AGENTS = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_AGENTS*NUM_FLAGS-1:0]  agent_set,
   input  logic [NUM_AGENTS*NUM_FLAGS-1:0]  agent_clr,
   input  logic [NUM_FLAGS-1:0]             host_set,
   input  logic [NUM_FLAGS-1:0]             host_clr,
   output logic [NUM_FLAGS-1:0]             flags
);

   logic [NUM_FLAGS-1:0] any_set;
   logic [NUM_FLAGS-1:0] any_clr;
   logic [NUM_FLAGS-1:0] flags_q;

   always_comb begin
      any_set = host_set;
      any_clr = host_clr;
      for (int a = 0; a < int'(NUM_AGENTS); a++) begin
         any_set = any_set | agent_set[a*NUM_FLAGS +: NUM_FLAGS];
         any_clr = any_clr | agent_clr[a*NUM_FLAGS +: NUM_FLAGS];
      end
   end

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~any_clr) | any_set;
   end

   assign flags = flags_q;

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (agent_set == '0 && agent_clr == '0 && host_set == '0 && host_clr == '0)
      |=> $stable(flags_q));

   for (genvar f = 0; f < int'(NUM_FLAGS); f++) begin : g_flag_chk
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         any_set[f] |=> flags_q[f]);
      assert_host_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (host_clr[f] && !any_set[f]) |=> !flags_q[f]);
   end

endmodule

// File: rtl/evf_wait_port.sv
module evf_wait_port #(
   parameter int unsigned NUM_FLAGS = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 pol,
   output logic                 met
);

   if (NUM_FLAGS == (1 << IDX_W)) begin : g_full
      assign met = (flags[idx] == pol);
   end else begin : g_checked
      // indices beyond the bank never satisfy a wait
      always_comb begin
         met = 1'b0;
         for (int f = 0; f < int'(NUM_FLAGS); f++)
            if (idx == IDX_W'(f)) met = (flags[f] == pol);
      end
   end

endmodule

// File: rtl/evf_irq_line.sv
module evf_irq_line #(
   parameter int unsigned RAW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_reg,
   input  logic             wr_force_reg,
   input  logic [RAW_W-1:0] wdata,
   input  logic [RAW_W-1:0] raw,
   output logic [RAW_W-1:0] en,
   output logic [RAW_W-1:0] frc,
   output logic [RAW_W-1:0] stat,
   output logic             irq
);

   logic [RAW_W-1:0] en_q;
   logic [RAW_W-1:0] frc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         frc_q <= '0;
      end else begin
         if (wr_en_reg)    en_q  <= wdata;
         if (wr_force_reg) frc_q <= wdata;
      end
   end

   assign en   = en_q;
   assign frc  = frc_q;
   assign stat = (raw | frc_q) & en_q;
   assign irq  = |stat;

   assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_reg |=> $stable(en_q));
   assert_force_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_force_reg |=> $stable(frc_q));

endmodule

// File: rtl/evflag_irq_unit.sv
module evflag_irq_unit #(
   parameter int unsigned NUM_FLAGS  = 8,
   parameter int unsigned NUM_AGENTS = 4,
   parameter int unsigned NUM_CHAN   = 4,
   parameter int unsigned NUM_LINES  = 2,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   localparam int unsigned IDX_W     = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1,
   localparam int unsigned RAW_W     = 3 * NUM_CHAN
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_AGENTS*NUM_FLAGS-1:0] agent_set,
   input  logic [NUM_AGENTS*NUM_FLAGS-1:0] agent_clr,
   input  logic [NUM_AGENTS*IDX_W-1:0]     wait_idx,
   input  logic [NUM_AGENTS-1:0]           wait_pol,
   output logic [NUM_AGENTS-1:0]           wait_met,
   input  logic [NUM_CHAN-1:0]             rx_not_empty,
   input  logic [NUM_CHAN-1:0]             tx_not_full,
   input  logic                            host_wr,
   input  logic [ADDR_W-1:0]               host_addr,
   input  logic [DATA_W-1:0]               host_wdata,
   output logic [DATA_W-1:0]               host_rdata,
   output logic [NUM_LINES-1:0]            irq_out
);
   import evf_pkg::*;

   // elaboration checks
   if (NUM_CHAN > NUM_FLAGS) begin : g_bad_chan
      $error("NUM_CHAN must not exceed NUM_FLAGS");
   end
   if (RAW_W > DATA_W || NUM_FLAGS > DATA_W) begin : g_bad_width
      $error("DATA_W too narrow for the flag bank or raw vector");
   end
   if (REG_LINE_BASE + LINE_STRIDE * NUM_LINES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the line registers");
   end
   if (NUM_LINES < 1 || NUM_AGENTS < 1 || NUM_FLAGS < 2) begin : g_bad_count
      $error("counts out of range");
   end

   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(REG_FLAGS);
   localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(REG_FLAG_SET);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(REG_RAW);

   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] host_set;
   logic [NUM_FLAGS-1:0] host_clr;
   logic [RAW_W-1:0]     raw;
   logic [RAW_W-1:0]     line_en   [NUM_LINES];
   logic [RAW_W-1:0]     line_frc  [NUM_LINES];
   logic [RAW_W-1:0]     line_stat [NUM_LINES];
   logic [NUM_LINES-1:0] wr_force_any;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^host_wdata[DATA_W-1:RAW_W];

   assign host_clr = (host_wr && host_addr == A_FLAGS) ? host_wdata[NUM_FLAGS-1:0] : '0;
   assign host_set = (host_wr && host_addr == A_SET)   ? host_wdata[NUM_FLAGS-1:0] : '0;

   evf_flag_bank #(
      .NUM_FLAGS  (NUM_FLAGS),
      .NUM_AGENTS (NUM_AGENTS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .agent_set (agent_set),
      .agent_clr (agent_clr),
      .host_set  (host_set),
      .host_clr  (host_clr),
      .flags     (flags)
   );

   for (genvar a = 0; a < int'(NUM_AGENTS); a++) begin : g_wait
      evf_wait_port #(
         .NUM_FLAGS (NUM_FLAGS),
         .IDX_W     (IDX_W)
      ) u_wait (
         .flags (flags),
         .idx   (wait_idx[a*IDX_W +: IDX_W]),
         .pol   (wait_pol[a]),
         .met   (wait_met[a])
      );
   end

   assign raw = {flags[NUM_CHAN-1:0], tx_not_full, rx_not_empty};

   for (genvar k = 0; k < int'(NUM_LINES); k++) begin : g_line
      localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(line_reg(k, SLOT_EN));
      localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(line_reg(k, SLOT_FORCE));
      logic wr_en_k;
      logic wr_frc_k;
      assign wr_en_k         = host_wr && host_addr == A_EN;
      assign wr_frc_k        = host_wr && host_addr == A_FRC;
      assign wr_force_any[k] = wr_frc_k;

      evf_irq_line #(
         .RAW_W (RAW_W)
      ) u_line (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_en_reg    (wr_en_k),
         .wr_force_reg (wr_frc_k),
         .wdata        (host_wdata[RAW_W-1:0]),
         .raw          (raw),
         .en           (line_en[k]),
         .frc          (line_frc[k]),
         .stat         (line_stat[k]),
         .irq          (irq_out[k])
      );
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == A_FLAGS) host_rdata[NUM_FLAGS-1:0] = flags;
      if (host_addr == A_RAW)   host_rdata[RAW_W-1:0]     = raw;
      for (int k = 0; k < int'(NUM_LINES); k++) begin
         if (host_addr == ADDR_W'(line_reg(k, SLOT_EN)))    host_rdata[RAW_W-1:0] = line_en[k];
         if (host_addr == ADDR_W'(line_reg(k, SLOT_FORCE))) host_rdata[RAW_W-1:0] = line_frc[k];
         if (host_addr == ADDR_W'(line_reg(k, SLOT_STAT)))  host_rdata[RAW_W-1:0] = line_stat[k];
      end
   end

   assert_force_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_force_any && agent_set == '0 && agent_clr == '0) |=> $stable(flags));

endmodule

// File: tb/evflag_irq_unit_test.sv
`timescale 1ns/1ps
module evflag_irq_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] agent_set = '0;
   logic [31:0] agent_clr = '0;
   logic [11:0] wait_idx = '0;
   logic [3:0]  wait_pol = '0;
   logic [3:0]  wait_met;
   logic [3:0]  rx_not_empty = '0;
   logic [3:0]  tx_not_full = '0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [1:0]  irq_out;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [31:0] rd;

   always #2 clk = ~clk;

   evflag_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .agent_set(agent_set), .agent_clr(agent_clr),
      .wait_idx(wait_idx), .wait_pol(wait_pol), .wait_met(wait_met),
      .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq_out(irq_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d expected<50000 cycles", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0;
   endtask

   task automatic hread(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b0; host_addr = a;
      #1 d = host_rdata;
   endtask

   // {rx[3:0], tx[3:0], flags[7:0], en0, frc0, en1, frc1}
   localparam int NV = 6;
   localparam logic [63:0] VEC [NV] = '{
      {4'h1, 4'h0, 8'h00, 12'h001, 12'h000, 12'h000, 12'h000},
      {4'h0, 4'hA, 8'h00, 12'h00F, 12'h000, 12'h0A0, 12'h000},
      {4'h0, 4'h0, 8'h05, 12'h500, 12'h000, 12'h000, 12'h000},
      {4'h0, 4'h0, 8'hF0, 12'hFFF, 12'h000, 12'hFFF, 12'h000},
      {4'h0, 4'h0, 8'h00, 12'h800, 12'h800, 12'h000, 12'hFFF},
      {4'hF, 4'h0, 8'h00, 12'h000, 12'h000, 12'h003, 12'h100}
   };

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      #1;
      chk("R1 reset irq", {30'd0, irq_out}, 32'h0);
      chk("R5 reset wait pol0", {28'd0, wait_met}, 32'hF);
      rst_n = 1'b1;
      hread(4'd0, rd); chk("R1 reset flags", rd, 32'h0);
      hread(4'd3, rd); chk("R7 reset en0", rd, 32'h0);
      hread(4'd7, rd); chk("R7 reset frc1", rd, 32'h0);

      // table walk over the interrupt path
      for (int v = 0; v < NV; v++) begin
         logic [3:0]  vrx, vtx;
         logic [7:0]  vfl;
         logic [11:0] e0, f0, e1, f1, eraw, es0, es1;
         {vrx, vtx, vfl, e0, f0, e1, f1} = VEC[v];
         hwrite(4'd0, 32'hFF);
         hwrite(4'd1, {24'd0, vfl});
         hwrite(4'd3, {20'd0, e0});
         hwrite(4'd4, {20'd0, f0});
         hwrite(4'd6, {20'd0, e1});
         hwrite(4'd7, {20'd0, f1});
         @(negedge clk);
         rx_not_empty = vrx; tx_not_full = vtx;
         eraw = {vfl[3:0], vtx, vrx};
         es0 = (eraw | f0) & e0;
         es1 = (eraw | f1) & e1;
         hread(4'd0, rd); chk($sformatf("R3 vec%0d flags", v), rd, {24'd0, vfl});
         hread(4'd2, rd); chk($sformatf("R6 vec%0d raw", v), rd, {20'd0, eraw});
         hread(4'd5, rd); chk($sformatf("R7 vec%0d stat0", v), rd, {20'd0, es0});
         hread(4'd8, rd); chk($sformatf("R7 vec%0d stat1", v), rd, {20'd0, es1});
         chk($sformatf("R7 vec%0d irq", v), {30'd0, irq_out}, {30'd0, |es1, |es0});
      end

      // tidy up
      @(negedge clk); rx_not_empty = '0; tx_not_full = '0;
      hwrite(4'd0, 32'hFF);
      hwrite(4'd3, 0); hwrite(4'd4, 0); hwrite(4'd6, 0); hwrite(4'd7, 0);

      // R1: agent 2 sets flag 5
      @(negedge clk); agent_set[21] = 1'b1;
      @(negedge clk); agent_set = '0;
      wait_idx = {3'd0, 3'd0, 3'd5, 3'd5}; wait_pol = 4'b0010;
      hread(4'd0, rd); chk("R1 agent set", rd, 32'h20);
      chk("R5 wait met", {28'd0, wait_met}, 32'b1110);

      // R1: agent 3 clears flag 5
      @(negedge clk); agent_clr[29] = 1'b1;
      @(negedge clk); agent_clr = '0;
      hread(4'd0, rd); chk("R1 agent clear", rd, 32'h0);
      chk("R5 wait after clear", {28'd0, wait_met}, 32'b1101);

      // R3 / R2
      hwrite(4'd1, 32'h20);
      #1 chk("R3 wait sees host set", {28'd0, wait_met}, 32'b1110);
      hwrite(4'd0, 32'h00);
      hread(4'd0, rd); chk("R2 write zero keeps", rd, 32'h20);
      hwrite(4'd0, 32'h20);
      hread(4'd0, rd); chk("R2 write one clears", rd, 32'h0);

      // R4: set versus clear in the same cycle
      @(negedge clk);
      agent_set[3] = 1'b1; host_wr = 1'b1; host_addr = 4'd0; host_wdata = 32'h08;
      agent_set[9] = 1'b1; agent_clr[17] = 1'b1;
      @(negedge clk);
      agent_set = '0; agent_clr = '0; host_wr = 1'b0; host_wdata = '0;
      hread(4'd0, rd); chk("R4 set beats clear", rd, 32'h0A);

      // R8: line force leaves flags and raw alone
      hwrite(4'd6, 32'h001);
      hwrite(4'd7, 32'hFFF);
      hread(4'd0, rd); chk("R8 flags after force", rd, 32'h0A);
      hread(4'd2, rd); chk("R8 raw after force", rd, 32'hA00);
      chk("R8 irq by force", {30'd0, irq_out}, 32'b10);
      hread(4'd6, rd); chk("R7 en1 readback", rd, 32'h001);
      hread(4'd7, rd); chk("R7 frc1 readback", rd, 32'hFFF);

      // R9: read-only and unmapped addresses
      hwrite(4'd2, 32'hFFF);
      hwrite(4'd5, 32'hFFF);
      hwrite(4'd15, 32'hFF);
      hread(4'd2, rd); chk("R9 raw unchanged", rd, 32'hA00);
      hread(4'd5, rd); chk("R9 stat0 unchanged", rd, 32'h0);
      hread(4'd0, rd); chk("R9 flags unchanged", rd, 32'h0A);
      hread(4'd1, rd); chk("R9 set reg reads zero", rd, 32'h0);
      hread(4'd3, rd); chk("R9 en0 unchanged", rd, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule